// File: doc/BRIEF.md
# Timekeeping Counters with Alarms

This block keeps three free-running binary counters: a real-time count, an interval count and a power-cycle count. Each counter has an alarm register of the same width. It also holds a status byte, made of alarm flags and interrupt masks, and a control byte. The real-time count and the interval count advance on a 256 Hz tick. The interval count can be gated by hand or by the filtered level of the data line. The cycle count advances on each filtered falling edge of that line. The filter needs the line to hold its new level for a delay chosen by one control bit.

Software reaches the block through a byte-wide register window at addresses 0200h to 021Dh. A snapshot pulse, issued when a read command starts, copies every counter into a holding register, so a multi-byte read sees one consistent value. The write-protect bits take effect only after the same protect pattern is written three times in a row. Once set, they freeze the matching counter and alarm and part of the control byte. If a protected alarm then fires, the block expires: it becomes read-only or fully closed.

Top module: `tk_timekeeper`

## Requirements
- R1: After reset every register, flag, lock and expiry state is zero. `rd_data_o` is 00h, `irq_o` is 0, and `rd_ok_o` and `wr_ok_o` are both 1.
- R2: The real-time count rises by one on each tick while control bit 4 (oscillator enable) is 1. While that bit is 0, no counter advances.
- R3: Each counter wraps to zero after its all-ones value.
- R4: A pulse on `snap_i` copies all three counters into holding registers. Reads of counter bytes (0202h–0206h real-time, 0207h–020Bh interval, 020Ch–020Fh cycle, lowest byte at the lowest address) return the held value. Reads outside 0200h–021Dh return FFh. Read data appears one cycle after `rd_en_i`.
- R5: With control bit 5 = 0 (manual), the interval count advances on ticks while control bit 6 is 0 and holds while it is 1.
- R6: With control bit 5 = 1 (auto), the interval count advances on ticks only while the filtered line level is high.
- R7: The cycle count rises by one when the filtered line level falls. A low pulse shorter than the filter delay is ignored.
- R8: Control bit 7 selects the long filter delay (`DLY_LONG` cycles) when 1 and the short one (`DLY_SHORT`) when 0.
- R9: When a counter steps onto its alarm value (alarms at 0210h, 0215h, 021Ah), status bit 0, 1 or 2 is set for the real-time, interval or cycle count. A status read (0200h) returns the flags and then clears all of them. A new alarm in the same cycle wins over the clear.
- R10: Status bits 3–5 are per-alarm masks. `irq_o` is 1 while any flag is set and its mask bit is 0.
- R11: Control bits 0–2 (protect: real-time, interval, cycle) are set only by the third consecutive control write with the same non-zero protect field. Any other write in between restarts the count. Once any protect bit is set, the protect bits never change again.
- R12: A protect bit freezes its counter and alarm. Any protect bit freezes bit 3 (read-only select) and makes bit 4 settable but not clearable. Protecting the interval or cycle count also freezes bits 5 and 7 and forces bit 6 to 0.
- R13: When a protected counter's alarm fires, the block expires until reset. All writes are ignored and `wr_ok_o` is 0. If bit 3 is 1, reads continue; otherwise `rd_ok_o` is 0 and reads return FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | 256 Hz single-cycle enable |
| line_i | input | 1 | Sampled data-line level |
| snap_i | input | 1 | Read-command start, loads holding registers |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 16 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Interrupt pending |
| rd_ok_o | output | 1 | Read commands allowed |
| wr_ok_o | output | 1 | Write commands allowed |

## Verification
The bench rolls the real-time count over from all-ones onto an alarm of zero. A design with a carry error or an equality test made before the increment would miss that flag. It drives line pulses just shorter than each filter delay and then longer ones. A filter that counted cycles wrongly, or ignored the delay select, would count cycles it should skip. It breaks the three-write protect sequence with an unrelated write and checks that the lock is still clear. It then checks that frozen fields, the set-only oscillator bit, and both expiry modes act only on a protected alarm.

// File: rtl/tk_pkg.sv
package tk_pkg;

   localparam logic [15:0] TK_BASE = 16'h0200;

   localparam int OFF_STAT = 0;
   localparam int OFF_CTRL = 1;
   localparam int OFF_CNT0 = 2;

   typedef struct packed {
      logic       dsel;
      logic       stop;
      logic       auto_m;
      logic       osc;
      logic       ro;
      logic [2:0] wp;
   } tk_ctrl_t;

   localparam int WP_RTC = 0;
   localparam int WP_ITV = 1;
   localparam int WP_CYC = 2;

endpackage

// File: rtl/tk_line_filter.sv
module tk_line_filter #(
   parameter int DLY_SHORT = 8,
   parameter int DLY_LONG  = 40,
   localparam int CW = $clog2(DLY_LONG + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic long_i,
   output logic level_o,
   output logic fall_o
);

   logic          level_q;
   logic [CW-1:0] run_q;
   logic [CW-1:0] lim;
   logic          differ;
   logic          flip;

   assign lim    = long_i ? CW'(DLY_LONG - 1) : CW'(DLY_SHORT - 1);
   assign differ = line_i != level_q;
   assign flip   = differ && (run_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         run_q   <= '0;
      end else if (!differ) begin
         run_q <= '0;
      end else if (flip) begin
         level_q <= line_i;
         run_q   <= '0;
      end else begin
         run_q <= run_q + CW'(1);
      end
   end

   assign level_o = level_q;
   assign fall_o  = flip & level_q;

endmodule

// File: rtl/tk_count.sv
module tk_count #(
   parameter int NB = 5,
   localparam int W = NB * 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         snap_i,
   input  logic         lock_i,
   input  logic         wr_cnt_i,
   input  logic         wr_alm_i,
   input  logic [2:0]   wr_idx_i,
   input  logic [7:0]   wr_data_i,
   output logic [W-1:0] hold_o,
   output logic [W-1:0] alarm_o,
   output logic         hit_o
);

   logic [W-1:0] cnt_q;
   logic [W-1:0] alm_q;
   logic [W-1:0] hold_q;
   logic [W-1:0] lane_m;
   logic [W-1:0] cnt_inc;
   logic [W-1:0] wr_rep;
   logic         wr_c;
   logic         wr_a;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign lane_m[b*8 +: 8] = (wr_idx_i == 3'(b)) ? 8'hFF : 8'h00;
      assign wr_rep[b*8 +: 8] = wr_data_i;
   end

   assign wr_c    = wr_cnt_i & ~lock_i;
   assign wr_a    = wr_alm_i & ~lock_i;
   assign cnt_inc = cnt_q + W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         alm_q  <= '0;
         hold_q <= '0;
      end else begin
         if (wr_c)
            cnt_q <= (cnt_q & ~lane_m) | (wr_rep & lane_m);
         else if (inc_i)
            cnt_q <= cnt_inc;
         if (wr_a)
            alm_q <= (alm_q & ~lane_m) | (wr_rep & lane_m);
         if (snap_i)
            hold_q <= cnt_q;
      end
   end

   assign hold_o  = hold_q;
   assign alarm_o = alm_q;
   assign hit_o   = inc_i & ~wr_c & (cnt_inc == alm_q);

endmodule

// File: rtl/tk_timekeeper.sv
module tk_timekeeper
   import tk_pkg::*;
#(
   parameter int RTC_BYTES = 5,
   parameter int ITV_BYTES = 5,
   parameter int CYC_BYTES = 4,
   parameter int DLY_SHORT = 14000,
   parameter int DLY_LONG  = 492000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_i,
   input  logic        line_i,
   input  logic        snap_i,
   input  logic        wr_en_i,
   input  logic        rd_en_i,
   input  logic [15:0] addr_i,
   input  logic [7:0]  wr_data_i,
   output logic [7:0]  rd_data_o,
   output logic        irq_o,
   output logic        rd_ok_o,
   output logic        wr_ok_o
);

   localparam int RW      = RTC_BYTES * 8;
   localparam int IW      = ITV_BYTES * 8;
   localparam int CW      = CYC_BYTES * 8;
   localparam int OFF_RTC = OFF_CNT0;
   localparam int OFF_ITV = OFF_RTC + RTC_BYTES;
   localparam int OFF_CYC = OFF_ITV + ITV_BYTES;
   localparam int OFF_RTA = OFF_CYC + CYC_BYTES;
   localparam int OFF_ITA = OFF_RTA + RTC_BYTES;
   localparam int OFF_CYA = OFF_ITA + ITV_BYTES;
   localparam int OFF_END = OFF_CYA + CYC_BYTES - 1;

   if (RTC_BYTES < 1 || RTC_BYTES > 8 || ITV_BYTES < 1 || ITV_BYTES > 8 ||
       CYC_BYTES < 1 || CYC_BYTES > 8) begin : g_bad_width
      $error("tk_timekeeper: counter byte counts must be 1..8");
   end
   if (DLY_SHORT < 1 || DLY_LONG <= DLY_SHORT) begin : g_bad_dly
      $error("tk_timekeeper: need 1 <= DLY_SHORT < DLY_LONG");
   end
   if (OFF_END > 255) begin : g_bad_map
      $error("tk_timekeeper: register window too large");
   end

   // address decode
   logic [15:0] off;
   logic [7:0]  off8;
   logic        in_map;
   logic        wr_acc;
   logic        rd_acc;
   logic        rd_ok;
   logic        expired_q;

   tk_ctrl_t    ctrl_q;
   logic [2:0]  flag_q;
   logic [2:0]  en_q;
   logic [1:0]  arm_cnt_q;
   logic [2:0]  arm_val_q;
   logic [7:0]  rd_data_q;

   assign off    = addr_i - TK_BASE;
   assign off8   = off[7:0];
   assign in_map = (addr_i >= TK_BASE) && (off <= 16'(OFF_END));
   assign rd_ok  = ~expired_q | ctrl_q.ro;
   assign wr_acc = wr_en_i & in_map & ~expired_q;
   assign rd_acc = rd_en_i & in_map & rd_ok;

   function automatic logic in_rng(input logic [7:0] o, input int lo, input int n);
      return (int'(o) >= lo) && (int'(o) < lo + n);
   endfunction

   logic wr_rtc, wr_itv, wr_cyc, wr_rta, wr_ita, wr_cya;
   logic wr_stat, wr_ctrl, rd_stat;
   assign wr_rtc  = wr_acc && in_rng(off8, OFF_RTC, RTC_BYTES);
   assign wr_itv  = wr_acc && in_rng(off8, OFF_ITV, ITV_BYTES);
   assign wr_cyc  = wr_acc && in_rng(off8, OFF_CYC, CYC_BYTES);
   assign wr_rta  = wr_acc && in_rng(off8, OFF_RTA, RTC_BYTES);
   assign wr_ita  = wr_acc && in_rng(off8, OFF_ITA, ITV_BYTES);
   assign wr_cya  = wr_acc && in_rng(off8, OFF_CYA, CYC_BYTES);
   assign wr_stat = wr_acc && (off8 == 8'(OFF_STAT));
   assign wr_ctrl = wr_acc && (off8 == 8'(OFF_CTRL));
   assign rd_stat = rd_acc && (off8 == 8'(OFF_STAT));

   logic [7:0] k_rtc, k_itv, k_cyc, k_rta, k_ita, k_cya;
   assign k_rtc = off8 - 8'(OFF_RTC);
   assign k_itv = off8 - 8'(OFF_ITV);
   assign k_cyc = off8 - 8'(OFF_CYC);
   assign k_rta = off8 - 8'(OFF_RTA);
   assign k_ita = off8 - 8'(OFF_ITA);
   assign k_cya = off8 - 8'(OFF_CYA);

   // line filter and counter enables
   logic line_lvl, line_fall;
   logic rtc_inc, itv_inc, cyc_inc, itv_run;
   logic rtc_hit, itv_hit, cyc_hit;
   logic [2:0] hits;

   tk_line_filter #(.DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .long_i(ctrl_q.dsel),
      .level_o(line_lvl), .fall_o(line_fall)
   );

   assign itv_run = ctrl_q.auto_m ? line_lvl : ~ctrl_q.stop;
   assign rtc_inc = tick_i & ctrl_q.osc;
   assign itv_inc = tick_i & ctrl_q.osc & itv_run;
   assign cyc_inc = line_fall & ctrl_q.osc;

   logic [RW-1:0] rtc_hold, rta;
   logic [IW-1:0] itv_hold, ita;
   logic [CW-1:0] cyc_hold, cya;

   tk_count #(.NB(RTC_BYTES)) u_rtc (
      .clk(clk), .rst_n(rst_n), .inc_i(rtc_inc), .snap_i(snap_i),
      .lock_i(ctrl_q.wp[WP_RTC]), .wr_cnt_i(wr_rtc), .wr_alm_i(wr_rta),
      .wr_idx_i(wr_rtc ? k_rtc[2:0] : k_rta[2:0]), .wr_data_i(wr_data_i),
      .hold_o(rtc_hold), .alarm_o(rta), .hit_o(rtc_hit)
   );

   tk_count #(.NB(ITV_BYTES)) u_itv (
      .clk(clk), .rst_n(rst_n), .inc_i(itv_inc), .snap_i(snap_i),
      .lock_i(ctrl_q.wp[WP_ITV]), .wr_cnt_i(wr_itv), .wr_alm_i(wr_ita),
      .wr_idx_i(wr_itv ? k_itv[2:0] : k_ita[2:0]), .wr_data_i(wr_data_i),
      .hold_o(itv_hold), .alarm_o(ita), .hit_o(itv_hit)
   );

   tk_count #(.NB(CYC_BYTES)) u_cyc (
      .clk(clk), .rst_n(rst_n), .inc_i(cyc_inc), .snap_i(snap_i),
      .lock_i(ctrl_q.wp[WP_CYC]), .wr_cnt_i(wr_cyc), .wr_alm_i(wr_cya),
      .wr_idx_i(wr_cyc ? k_cyc[2:0] : k_cya[2:0]), .wr_data_i(wr_data_i),
      .hold_o(cyc_hold), .alarm_o(cya), .hit_o(cyc_hit)
   );

   assign hits = {cyc_hit, itv_hit, rtc_hit};

   // status, expiry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q    <= '0;
         en_q      <= '0;
         expired_q <= 1'b0;
      end else begin
         flag_q    <= (flag_q & ~{3{rd_stat}}) | hits;
         expired_q <= expired_q | (|(hits & ctrl_q.wp));
         if (wr_stat)
            en_q <= wr_data_i[5:3];
      end
   end

   // control register with protect arming
   logic       any_wp, lock_b;
   logic [2:0] new_wp;
   logic [1:0] arm_nxt;
   assign any_wp  = |ctrl_q.wp;
   assign lock_b  = ctrl_q.wp[WP_ITV] | ctrl_q.wp[WP_CYC];
   assign new_wp  = wr_data_i[2:0];
   assign arm_nxt = (arm_cnt_q != 2'd0 && new_wp == arm_val_q) ? arm_cnt_q + 2'd1 : 2'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         arm_cnt_q <= '0;
         arm_val_q <= '0;
      end else begin
         if (lock_b)
            ctrl_q.stop <= 1'b0;
         if (wr_ctrl) begin
            if (!lock_b) begin
               ctrl_q.dsel   <= wr_data_i[7];
               ctrl_q.stop   <= wr_data_i[6];
               ctrl_q.auto_m <= wr_data_i[5];
            end
            if (any_wp) begin
               ctrl_q.osc <= ctrl_q.osc | wr_data_i[4];
            end else begin
               ctrl_q.osc <= wr_data_i[4];
               ctrl_q.ro  <= wr_data_i[3];
            end
         end
         if (wr_acc) begin
            if (wr_ctrl && !any_wp && new_wp != 3'd0) begin
               if (arm_nxt == 2'd3) begin
                  ctrl_q.wp <= new_wp;
                  arm_cnt_q <= 2'd0;
               end else begin
                  arm_cnt_q <= arm_nxt;
                  arm_val_q <= new_wp;
               end
            end else begin
               arm_cnt_q <= 2'd0;
            end
         end
      end
   end

   // read path
   logic [7:0] rd_mux;
   always_comb begin
      rd_mux = 8'hFF;
      if (off8 == 8'(OFF_STAT))
         rd_mux = {2'b00, en_q, flag_q};
      else if (off8 == 8'(OFF_CTRL))
         rd_mux = ctrl_q;
      else if (in_rng(off8, OFF_RTC, RTC_BYTES))
         rd_mux = 8'(rtc_hold >> (8 * k_rtc));
      else if (in_rng(off8, OFF_ITV, ITV_BYTES))
         rd_mux = 8'(itv_hold >> (8 * k_itv));
      else if (in_rng(off8, OFF_CYC, CYC_BYTES))
         rd_mux = 8'(cyc_hold >> (8 * k_cyc));
      else if (in_rng(off8, OFF_RTA, RTC_BYTES))
         rd_mux = 8'(rta >> (8 * k_rta));
      else if (in_rng(off8, OFF_ITA, ITV_BYTES))
         rd_mux = 8'(ita >> (8 * k_ita));
      else if (in_rng(off8, OFF_CYA, CYC_BYTES))
         rd_mux = 8'(cya >> (8 * k_cya));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data_q <= '0;
      else if (rd_en_i)
         rd_data_q <= rd_acc ? rd_mux : 8'hFF;
   end

   assign rd_data_o = rd_data_q;
   assign irq_o     = |(flag_q & ~en_q);
   assign rd_ok_o   = rd_ok;
   assign wr_ok_o   = ~expired_q;

endmodule

// File: rtl/tk_timekeeper_chk.sv
module tk_timekeeper_chk #(
   parameter int RW = 40
) (
   input logic          clk,
   input logic          rst_n,
   input logic          osc,
   input logic          rd_stat,
   input logic [2:0]    flag_q,
   input logic          irq_o,
   input logic [2:0]    wp,
   input logic [RW-1:0] rta,
   input logic          wr_ok_o
);

   assert_osc_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc && !rd_stat) |=> $stable(flag_q));

   assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !osc) |=> (flag_q == 3'b000));

   assert_irq_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !osc) |=> !irq_o);

   assert_wp_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wp != 3'b000) |=> (wp == $past(wp)));

   assert_alarm_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wp[0] |=> $stable(rta));

   assert_expired_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok_o |=> !wr_ok_o);

endmodule

bind tk_timekeeper tk_timekeeper_chk #(.RW(RW)) u_chk (
   .clk(clk), .rst_n(rst_n), .osc(ctrl_q.osc), .rd_stat(rd_stat),
   .flag_q(flag_q), .irq_o(irq_o), .wp(ctrl_q.wp), .rta(rta), .wr_ok_o(wr_ok_o)
);

// File: tb/tk_timekeeper_tb.sv
`timescale 1ns/1ps
module tk_timekeeper_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, line = 1'b0, snap = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rd_data;
   logic        irq, rd_ok, wr_ok;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2 clk = ~clk;

   tk_timekeeper #(.DLY_SHORT(8), .DLY_LONG(40)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(line), .snap_i(snap),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wr_data_i(wdata),
      .rd_data_o(rd_data), .irq_o(irq), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok)
   );

   typedef struct {
      logic [7:0] v;
      string      tag;
   } exp_t;
   exp_t q[$];
   logic rd_d = 1'b0;

   always @(posedge clk) rd_d <= rd_en;

   // monitor: compare read data one cycle after the strobe
   always @(negedge clk) begin
      if (rd_d) begin
         exp_t e;
         e = q.pop_front();
         n_tests++;
         if (rd_data !== e.v) begin
            n_fail++;
            $display("FAIL %s: read data %02h expected %02h", e.tag, rd_data, e.v);
         end
      end
   end

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
      exp_t x;
      x.v = e; x.tag = tag;
      @(negedge clk); rd_en = 1; addr = a; q.push_back(x);
      @(negedge clk); rd_en = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1;
         @(negedge clk); tick = 0;
      end
   endtask

   task automatic snapshot();
      @(negedge clk); snap = 1;
      @(negedge clk); snap = 0;
   endtask

   task automatic line_for(input logic v, input int n);
      @(negedge clk); line = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic act, input logic exp, input string tag);
      @(negedge clk);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, got hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk(irq, 1'b0, "R1 irq");
      chk(rd_ok, 1'b1, "R1 rd_ok");
      chk(wr_ok, 1'b1, "R1 wr_ok");
      rd(16'h0200, 8'h00, "R1 status");
      rd(16'h0201, 8'h00, "R1 control");
      rd(16'h0202, 8'h00, "R1 rtc");
      // R4 outside window
      rd(16'h021E, 8'hFF, "R4 out of map");
      // R2 oscillator off
      ticks(3); snapshot();
      rd(16'h0202, 8'h00, "R2 osc off");
      wr(16'h0201, 8'h10);
      ticks(3); snapshot();
      rd(16'h0202, 8'h03, "R2 rtc ticks");
      rd(16'h0207, 8'h03, "R5 manual run");
      // R4 holding registers
      ticks(2);
      rd(16'h0202, 8'h03, "R4 hold stable");
      snapshot();
      rd(16'h0202, 8'h05, "R4 new snapshot");
      // R5 stop bit
      wr(16'h0201, 8'h50);
      ticks(2); snapshot();
      rd(16'h0207, 8'h05, "R5 stopped");
      rd(16'h0202, 8'h07, "R5 rtc still runs");
      // R3 rollover onto alarm zero
      for (int b = 0; b < 5; b++) wr(16'h0202 + 16'(b), 8'hFF);
      ticks(1); snapshot();
      rd(16'h0202, 8'h00, "R3 low byte");
      rd(16'h0206, 8'h00, "R3 high byte");
      chk(irq, 1'b1, "R10 irq unmasked");
      rd(16'h0200, 8'h01, "R9 flag set");
      rd(16'h0200, 8'h00, "R9 flag cleared");
      chk(irq, 1'b0, "R10 irq after read");
      // R10 masking
      wr(16'h0200, 8'h08);
      wr(16'h0210, 8'h02);
      ticks(2);
      chk(irq, 1'b0, "R10 masked");
      rd(16'h0200, 8'h09, "R9 masked flag");
      // R6 auto mode
      wr(16'h0201, 8'h30);
      ticks(2); snapshot();
      rd(16'h0207, 8'h05, "R6 line low");
      line_for(1'b1, 20);
      ticks(3); snapshot();
      rd(16'h0207, 8'h08, "R6 line high");
      // R7 cycle counter
      line_for(1'b0, 3);
      line_for(1'b1, 10);
      snapshot();
      rd(16'h020C, 8'h00, "R7 glitch ignored");
      line_for(1'b0, 20);
      snapshot();
      rd(16'h020C, 8'h01, "R7 counted fall");
      // R8 long delay
      wr(16'h0201, 8'hB0);
      line_for(1'b1, 60);
      line_for(1'b0, 20);
      line_for(1'b1, 5);
      snapshot();
      rd(16'h020C, 8'h01, "R8 long delay ignores");
      line_for(1'b0, 60);
      snapshot();
      rd(16'h020C, 8'h02, "R8 long delay counts");
      // R11 broken sequence
      wr(16'h0201, 8'h12);
      wr(16'h0201, 8'h12);
      wr(16'h0200, 8'h08);
      wr(16'h0201, 8'h12);
      rd(16'h0201, 8'h10, "R11 broken chain");
      wr(16'h0210, 8'h0A);
      wr(16'h0201, 8'h19);
      rd(16'h0201, 8'h18, "R11 first write");
      wr(16'h0201, 8'h19);
      rd(16'h0201, 8'h18, "R11 second write");
      wr(16'h0201, 8'h19);
      rd(16'h0201, 8'h19, "R11 third write");
      // R12 locks
      wr(16'h0202, 8'h77);
      snapshot();
      rd(16'h0202, 8'h07, "R12 counter locked");
      wr(16'h0201, 8'h02);
      rd(16'h0201, 8'h19, "R12 control locked");
      wr(16'h0210, 8'h55);
      rd(16'h0210, 8'h0A, "R12 alarm locked");
      // R13 expiry, read-only
      ticks(3);
      chk(wr_ok, 1'b0, "R13 wr_ok");
      chk(rd_ok, 1'b1, "R13 rd_ok read-only");
      rd(16'h0200, 8'h09, "R13 status readable");
      wr(16'h0200, 8'h00);
      rd(16'h0200, 8'h08, "R13 write ignored");
      // R13 expiry, closed
      do_reset();
      rd(16'h0201, 8'h00, "R1 control after reset");
      wr(16'h0210, 8'h01);
      wr(16'h0201, 8'h11);
      wr(16'h0201, 8'h11);
      wr(16'h0201, 8'h11);
      rd(16'h0201, 8'h11, "R11 armed");
      ticks(1);
      chk(rd_ok, 1'b0, "R13 rd_ok closed");
      chk(wr_ok, 1'b0, "R13 wr_ok closed");
      chk(irq, 1'b1, "R10 irq on expiry");
      rd(16'h0201, 8'hFF, "R13 read blocked");
      repeat (4) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule